// File: doc/BRIEF.md
# Single-Instruction Add Processor Datapath

This block is a single-cycle processor core whose whole instruction set is one operation: the register-register add. Every clock cycle the program counter selects a word from a small internal instruction store, three 5-bit register indices are cut out of that word at fixed positions, the two source registers are read and summed, and the sum is written into the destination register on the next rising edge. At that same edge the program counter steps by 4. There is no decoder, no data memory, no branch and no immediate path.

The instruction store is written through its own port, so a test environment can place a program in it, usually while the core is held in reset. Because an add can only build values out of values already present, a seed port writes a chosen value into a register. A seed write takes the register file's single write port for that cycle and freezes the core: the PC holds and the add in flight is dropped. Holding a seed write to register 0, which is ignored, is therefore a clean way to pause execution. A peek port returns any register's contents one cycle after the index is presented.

Top module: `addproc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register is cleared to 0.
- R2: At each rising edge with `rst` low and `seed_we` low, the PC advances by exactly 4, wrapping modulo 2^32.
- R3: The destination index is instruction bits [11:7], the first source index is bits [19:15] and the second source index is bits [24:20]; all other instruction bits have no effect on the result.
- R4: An executed instruction writes (rs1 value + rs2 value) modulo 2^32 into the destination register at the rising edge that ends its cycle.
- R5: Register 0 always reads as 0; writes to it, whether from an instruction or from the seed port, leave no trace.
- R6: An instruction reads the value written by the instruction immediately before it, with no stall.
- R7: With `seed_we` high and `rst` low, `seed_data` is written into register `seed_idx` at the next edge, the PC holds its value, and the instruction at the current PC is not executed in that cycle (it runs once the seed ends).
- R8: The instruction store has 256 words addressed by PC[9:2], read combinationally; once the PC passes byte address 1020 execution continues from word 0 again.
- R9: `peek_data` presents the contents of register `peek_idx` as sampled at the previous rising edge (one cycle of latency).
- R10: When the destination index equals a source index, the source operand is the register's old value, so `add xN,xN,xN` doubles xN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of PC and registers |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | 8 | Word index to write in the instruction store |
| imem_wdata | input | 32 | Instruction word to store |
| seed_we | input | 1 | Seed write enable; also freezes the core for the cycle |
| seed_idx | input | 5 | Register to seed |
| seed_data | input | 32 | Value to seed |
| peek_idx | input | 5 | Register to observe |
| peek_data | output | 32 | Registered contents of the observed register |
| pc | output | 32 | Current program counter |

## Verification
An instruction's sum lands in its destination at the edge that closes its cycle, and it becomes visible on `peek_data` only one edge after the peek index is presented, so the bench freezes the core with a seed write to register 0 before walking all 32 registers one per cycle and comparing against a model stepped once per executed cycle. The PC is due one edge after each run cycle and must stand still across every seed cycle, so it is compared after every single edge. Inputs change and outputs are sampled on the falling edge, halfway between the edge that produced a value and the next one.

// File: rtl/addproc_pkg.sv
package addproc_pkg;

  localparam int XLEN    = 32;
  localparam int NREG    = 32;
  localparam int REG_AW  = $clog2(NREG);
  localparam int PC_STEP = 4;

  // Fixed index field positions of the register-register format.
  localparam int RD_LSB  = 7;
  localparam int RS1_LSB = 15;
  localparam int RS2_LSB = 20;

  typedef struct packed {
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] srca;
    logic [REG_AW-1:0] srcb;
  } idx_fields_t;

  function automatic idx_fields_t cut_fields(input logic [XLEN-1:0] word);
    idx_fields_t f;
    f.dst  = word[RD_LSB  +: REG_AW];
    f.srca = word[RS1_LSB +: REG_AW];
    f.srcb = word[RS2_LSB +: REG_AW];
    return f;
  endfunction

endpackage

// File: rtl/addproc_pc.sv
module addproc_pc
  import addproc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  output logic [W-1:0] pc_q
);

  logic [W-1:0] pc_inc;

  // Dedicated incrementer feeding the PC register.
  always_comb pc_inc = pc_q + W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= '0;
    else if (!hold) pc_q <= pc_inc;
  end

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> (pc_q == '0));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (pc_q == $past(pc_q) + W'(PC_STEP)));

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(pc_q));

endmodule

// File: rtl/addproc_imem.sv
module addproc_imem
  import addproc_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Asynchronous read: the fetched word is valid in the same cycle as the PC.
  assign rdata = store[raddr];

endmodule

// File: rtl/addproc_regfile.sv
module addproc_regfile
  import addproc_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int N    = NREG,
  parameter int NRP  = 2,
  localparam int AW  = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRP-1:0][AW-1:0]  raddr,
  output logic [NRP-1:0][W-1:0]   rdata,
  input  logic [AW-1:0]           peek_idx,
  output logic [W-1:0]            peek_data
);

  logic [W-1:0] regs [N];

  // Register 0 is never written, so the reset value keeps it at zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  // Combinational operand read ports.
  for (genvar p = 0; p < NRP; p++) begin : g_rport
    assign rdata[p] = regs[raddr[p]];
  end

  // Registered observation port.
  always_ff @(posedge clk) begin
    peek_data <= regs[peek_idx];
  end

  // R1
  rf_reset_chk: assert property (@(posedge clk) rst |=> (rdata[0] == '0));

  // R4
  rf_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (we && (waddr != '0)) |=>
      ((raddr[0] != $past(waddr)) || (rdata[0] == $past(wdata))));

endmodule

// File: rtl/addproc_adder.sv
module addproc_adder
  import addproc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  // Carry out of the top bit is discarded: the sum wraps modulo 2^W.
  assign sum = a + b;

endmodule

// File: rtl/addproc_core.sv
module addproc_core
  import addproc_pkg::*;
#(
  parameter int IMEM_DEPTH = 256,
  localparam int IAW       = $clog2(IMEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              imem_we,
  input  logic [IAW-1:0]    imem_waddr,
  input  logic [XLEN-1:0]   imem_wdata,
  input  logic              seed_we,
  input  logic [REG_AW-1:0] seed_idx,
  input  logic [XLEN-1:0]   seed_data,
  input  logic [REG_AW-1:0] peek_idx,
  output logic [XLEN-1:0]   peek_data,
  output logic [XLEN-1:0]   pc
);

  logic [XLEN-1:0]             inst;
  idx_fields_t                 fld;
  logic [1:0][REG_AW-1:0]      src_idx;
  logic [1:0][XLEN-1:0]        src_val;
  logic [XLEN-1:0]             sum;
  logic                        rf_we;
  logic [REG_AW-1:0]           rf_waddr;
  logic [XLEN-1:0]             rf_wdata;
  logic                        unused_inst_bits;

  // Fetch
  addproc_pc #(.W(XLEN)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .hold (seed_we),
    .pc_q (pc)
  );

  addproc_imem #(.W(XLEN), .DEPTH(IMEM_DEPTH)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (imem_waddr),
    .wdata (imem_wdata),
    .raddr (pc[IAW+1:2]),
    .rdata (inst)
  );

  // Decode: fixed slices only, one instruction means no control.
  assign fld = cut_fields(inst);
  assign unused_inst_bits = ^{inst[XLEN-1:RS2_LSB+REG_AW],
                              inst[RS1_LSB-1:RD_LSB+REG_AW],
                              inst[RD_LSB-1:0]};
  assign src_idx[0] = fld.srca;
  assign src_idx[1] = fld.srcb;

  // Write port arbitration: a seed write takes the port and freezes the core.
  assign rf_we    = !rst;
  assign rf_waddr = seed_we ? seed_idx  : fld.dst;
  assign rf_wdata = seed_we ? seed_data : sum;

  addproc_regfile #(.W(XLEN), .N(NREG), .NRP(2)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we        (rf_we),
    .waddr     (rf_waddr),
    .wdata     (rf_wdata),
    .raddr     (src_idx),
    .rdata     (src_val),
    .peek_idx  (peek_idx),
    .peek_data (peek_data)
  );

  // Execute
  addproc_adder #(.W(XLEN)) u_add (
    .a   (src_val[0]),
    .b   (src_val[1]),
    .sum (sum)
  );

  // R5
  x0_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (fld.srca == '0) |-> (src_val[0] == '0));

endmodule

// File: tb/tb_addproc_core.sv
module tb_addproc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_we = 1'b0;
  logic [7:0]  imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic        seed_we = 1'b0;
  logic [4:0]  seed_idx = '0;
  logic [31:0] seed_data = '0;
  logic [4:0]  peek_idx = '0;
  logic [31:0] peek_data;
  logic [31:0] pc;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] prog [256];
  logic [31:0] mreg [32];
  logic [31:0] mpc;

  always #4 clk = ~clk;

  addproc_core dut (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .seed_we(seed_we), .seed_idx(seed_idx),
    .seed_data(seed_data), .peek_idx(peek_idx), .peek_data(peek_data), .pc(pc)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // Fields at [11:7], [19:15], [24:20]; every other bit is random filler (R3).
  function automatic logic [31:0] mk_add(input int rd, input int ra, input int rb);
    logic [31:0] w;
    w = $urandom;
    w[11:7]  = rd[4:0];
    w[19:15] = ra[4:0];
    w[24:20] = rb[4:0];
    return w;
  endfunction

  function automatic void model_step();
    logic [31:0] w, a, b;
    w = prog[mpc[9:2]];
    a = mreg[w[19:15]];
    b = mreg[w[24:20]];
    if (w[11:7] != 5'd0) mreg[w[11:7]] = a + b;
    mpc = mpc + 32'd4;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    mpc = '0;
  endfunction

  // Hold reset, write every instruction word, leave the core frozen after release.
  task automatic load_and_release();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      imem_we = 1'b1; imem_waddr = 8'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    model_reset();
    chk("R1 pc in reset", pc, 32'd0);
    seed_we = 1'b1; seed_idx = 5'd0; seed_data = 32'hDEAD_BEEF;
    rst = 1'b0;
    @(negedge clk);
    chk("R7 pc frozen after release", pc, 32'd0);
  endtask

  task automatic seed(input int idx, input logic [31:0] val);
    logic [31:0] pc0;
    pc0 = pc;
    seed_we = 1'b1; seed_idx = 5'(idx); seed_data = val;
    @(negedge clk);
    if (idx != 0) mreg[idx] = val;
    chk("R7 pc holds during seed", pc, pc0);
  endtask

  task automatic freeze();
    seed_we = 1'b1; seed_idx = 5'd0; seed_data = $urandom;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      seed_we = 1'b0;
      @(negedge clk);
      model_step();
      chk("R2 pc step", pc, mpc);
    end
    freeze();
  endtask

  task automatic peek_all(input string tag);
    freeze();
    for (int r = 0; r < 32; r++) begin
      peek_idx = 5'(r);
      @(negedge clk);
      chk($sformatf("%s R9 peek x%0d", tag, r), peek_data, mreg[r]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R2 got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);

    // R1: reset state, then reset in the middle of a seeded state.
    for (int i = 0; i < 256; i++) prog[i] = '0;
    load_and_release();
    peek_all("R1 after reset");
    for (int r = 0; r < 32; r++) seed(r, $urandom);
    peek_all("R7 seeded");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1 pc after mid reset", pc, 32'd0);
    peek_all("R1 cleared");

    // Directed: overflow wrap, x0 target, x0 source, doubling, chained use.
    for (int i = 0; i < 256; i++) prog[i] = '0;
    prog[0] = mk_add(4, 1, 2);   // FFFFFFFF + 1 wraps to 0 (R4)
    prog[1] = mk_add(0, 3, 3);   // write to x0 dropped (R5)
    prog[2] = mk_add(5, 0, 3);   // x0 source reads 0 (R5)
    prog[3] = mk_add(5, 5, 5);   // doubling reads old value (R10)
    prog[4] = mk_add(6, 5, 2);   // uses previous result (R6)
    prog[5] = mk_add(7, 6, 6);   // R6 chain
    load_and_release();
    for (int r = 1; r < 32; r++) seed(r, $urandom);
    seed(1, 32'hFFFF_FFFF);
    seed(2, 32'h0000_0001);
    seed(3, 32'h7FFF_FFFF);
    seed(0, 32'h1234_5678);      // R5 seed to x0 ignored
    run(8);
    peek_all("R4 R5 R6 R10 directed");
    peek_idx = 5'd5;
    @(negedge clk);
    chk("R10 doubled x5", peek_data, 32'hFFFF_FFFE);
    peek_idx = 5'd4;
    @(negedge clk);
    chk("R4 wrap x4", peek_data, 32'h0000_0000);

    // Random rounds with a seed write in the middle of execution (R7).
    for (int rnd = 0; rnd < 5; rnd++) begin
      for (int i = 0; i < 256; i++) prog[i] = '0;
      for (int i = 0; i < 40; i++) begin
        if (rnd < 2) prog[i] = mk_add($urandom % 8, $urandom % 8, $urandom % 8);
        else         prog[i] = mk_add($urandom % 32, $urandom % 32, $urandom % 32);
      end
      load_and_release();
      for (int r = 0; r < 32; r++) seed(r, $urandom);
      run(17);
      seed($urandom % 8, $urandom);
      seed(1 + $urandom % 31, $urandom);
      run(26);
      peek_all("R3 R4 R6 R7 random");
    end

    // R8: a full store of instructions, then wrap back to word 0.
    for (int i = 0; i < 256; i++) prog[i] = mk_add($urandom % 32, $urandom % 32, $urandom % 32);
    load_and_release();
    for (int r = 0; r < 32; r++) seed(r, $urandom);
    run(256);
    chk("R8 pc past last word", pc, 32'd1024);
    run(5);
    peek_all("R8 wrap");

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule